// File: doc/BRIEF.md
# Datapath FIFO Error Monitor

This block sits beside a cipher processing unit and watches the traffic at its input and output FIFOs, its completion events and its integrity comparison. Five error conditions are detected from FIFO occupancy sampled at particular events. Each condition has an enable mask bit. An unmasked error latches a sticky status bit, raises the error interrupt and freezes the engine through a halt output. A masked error is dropped entirely: it leaves no status, no interrupt and no halt.

The input FIFO occupancy is tracked inside the block from push and pop strobes, in words of `WORD_BYTES` bytes, against a capacity of `CAP_BYTES` bytes (256 by default). The output FIFO reports its own empty flag. Software reaches the mask and the status through a one-bit-address register port. Reads are combinational. Status bits are cleared by writing ones. A soft reset input clears the status and the input occupancy but leaves the mask unchanged.

Top module: `dp_fault_watch`

## Requirements
- R1: After reset the mask and status registers read 0, and `err_irq` and `halt` are low.
- R2: A pop of the output FIFO while `out_empty` is high detects status bit 2 (output underflow). A pop while the FIFO is not empty detects nothing.
- R3: The input occupancy counts pushes minus pops, up to CAP_BYTES/WORD_BYTES words (32 by default). A push while the occupancy is at that limit detects status bit 1 (input overflow), and the pushed word is not counted. Pushes up to the limit detect nothing.
- R4: A `done` pulse while the input occupancy is nonzero detects status bit 3 (input data left over). A `done` pulse with an empty input detects nothing.
- R5: A `size_wr` pulse while `out_empty` is low detects status bit 4 (output data left over). The same pulse with the output FIFO empty detects nothing.
- R6: A cycle with `icv_mismatch` high detects status bit 0 (integrity mismatch).
- R7: While mask bit i (address 0, bit i) is 1, an error of kind i leaves the status unchanged and raises neither `err_irq` nor `halt`.
- R8: An unmasked error detected in cycle t sets its status bit, `err_irq` and `halt` at the clock edge that ends cycle t.
- R9: Status bits are sticky. A write to address 1 clears exactly the bits written as 1. Bits written as 0 are unaffected. A new error detected in the same cycle as the write takes precedence.
- R10: `halt` stays high until every status bit has been cleared or `soft_rst` is pulsed. `soft_rst` clears all status bits and the input occupancy, and keeps the mask.
- R11: Several errors detected in the same cycle latch all of their unmasked status bits together.
- R12: Address 0 reads the mask and address 1 reads the status. Both are zero-extended to DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of status and input occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mask, 1 = status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| in_push | input | 1 | Input FIFO push strobe |
| in_pop | input | 1 | Input FIFO pop strobe |
| out_pop | input | 1 | Output FIFO read strobe |
| out_empty | input | 1 | Output FIFO empty flag |
| size_wr | input | 1 | Data-size register write strobe |
| done | input | 1 | Done interrupt generation strobe |
| icv_mismatch | input | 1 | Integrity compare mismatch flag |
| err_irq | output | 1 | Error interrupt |
| halt | output | 1 | Freeze request to the engine |

## Verification
The hardest situation to reach from the ports is the input overflow and the leftover-input error. Both need the internal occupancy brought to exactly its 32-word limit. The stimulus holds `in_push` for precisely 32 cycles and checks that no error appears. It then pushes once more, and later pulses `done` with the input still full. Masked handling is checked with a mixed pattern: several errors arrive in one cycle while only some kinds are masked, so that the status shows the unmasked subset.

// File: rtl/dp_fault_pkg.sv
package dp_fault_pkg;

   localparam int NUM_ERR     = 5;
   localparam int ERR_ICV     = 0;
   localparam int ERR_IN_OVF  = 1;
   localparam int ERR_OUT_UNF = 2;
   localparam int ERR_IN_LEFT = 3;
   localparam int ERR_OUT_LEFT = 4;

   typedef logic [NUM_ERR-1:0] err_vec_t;

   typedef enum logic {
      SEL_MASK = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/dp_fault_level.sv
module dp_fault_level #(
   parameter int WORD_BYTES = 8,
   parameter int CAP_BYTES  = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic push,
   input  logic pop,
   output logic full,
   output logic nonempty
);
   localparam int DEPTH = CAP_BYTES / WORD_BYTES;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   logic [LVL_W-1:0] lvl_q;
   logic             inc;
   logic             dec;

   assign full     = (lvl_q == LVL_MAX);
   assign nonempty = (lvl_q != '0);
   assign inc      = push && !full;
   assign dec      = pop && nonempty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (soft_rst) begin
         lvl_q <= '0;
      end else if (inc && !dec) begin
         lvl_q <= lvl_q + 1'b1;
      end else if (dec && !inc) begin
         lvl_q <= lvl_q - 1'b1;
      end
   end
endmodule

// File: rtl/dp_fault_detect.sv
module dp_fault_detect
   import dp_fault_pkg::*;
(
   input  logic     in_push,
   input  logic     in_full,
   input  logic     in_nonempty,
   input  logic     done,
   input  logic     out_pop,
   input  logic     out_empty,
   input  logic     size_wr,
   input  logic     icv_mismatch,
   output err_vec_t det
);
   always_comb begin
      det               = '0;
      det[ERR_ICV]      = icv_mismatch;
      det[ERR_IN_OVF]   = in_push && in_full;
      det[ERR_OUT_UNF]  = out_pop && out_empty;
      det[ERR_IN_LEFT]  = done && in_nonempty;
      det[ERR_OUT_LEFT] = size_wr && !out_empty;
   end
endmodule

// File: rtl/dp_fault_regs.sv
module dp_fault_regs
   import dp_fault_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  err_vec_t          det,
   output err_vec_t          mask_q,
   output err_vec_t          stat_q
);
   err_vec_t clr_vec;
   logic     wr_mask;
   logic     wr_stat;

   assign wr_mask = reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);
   assign wr_stat = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);
   assign clr_vec = wr_stat ? reg_wdata[NUM_ERR-1:0] : '0;

   generate
      if (DATA_W > NUM_ERR) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^reg_wdata[DATA_W-1:NUM_ERR];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= reg_wdata[NUM_ERR-1:0];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_ERR; gi++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat_q[gi] <= 1'b0;
            end else if (soft_rst) begin
               stat_q[gi] <= 1'b0;
            end else if (det[gi] && !mask_q[gi]) begin
               stat_q[gi] <= 1'b1;
            end else if (clr_vec[gi]) begin
               stat_q[gi] <= 1'b0;
            end
         end
      end
   endgenerate

   always_comb begin
      if (reg_sel_e'(reg_addr) == SEL_MASK) begin
         reg_rdata = DATA_W'(mask_q);
      end else begin
         reg_rdata = DATA_W'(stat_q);
      end
   end
endmodule

// File: rtl/dp_fault_watch.sv
module dp_fault_watch
   import dp_fault_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 8,
   parameter int CAP_BYTES  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              in_push,
   input  logic              in_pop,
   input  logic              out_pop,
   input  logic              out_empty,
   input  logic              size_wr,
   input  logic              done,
   input  logic              icv_mismatch,
   output logic              err_irq,
   output logic              halt
);
   initial begin : elab_chk
      if (DATA_W < NUM_ERR) $error("DATA_W must hold every status bit");
      if (WORD_BYTES < 1) $error("WORD_BYTES must be positive");
      if (CAP_BYTES % WORD_BYTES != 0) $error("CAP_BYTES must be a whole number of words");
      if (CAP_BYTES < WORD_BYTES) $error("capacity below one word");
   end

   logic     in_full;
   logic     in_nonempty;
   err_vec_t det_w;
   err_vec_t mask_q;
   err_vec_t stat_q;

   dp_fault_level #(
      .WORD_BYTES(WORD_BYTES),
      .CAP_BYTES (CAP_BYTES)
   ) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .push    (in_push),
      .pop     (in_pop),
      .full    (in_full),
      .nonempty(in_nonempty)
   );

   dp_fault_detect u_detect (
      .in_push     (in_push),
      .in_full     (in_full),
      .in_nonempty (in_nonempty),
      .done        (done),
      .out_pop     (out_pop),
      .out_empty   (out_empty),
      .size_wr     (size_wr),
      .icv_mismatch(icv_mismatch),
      .det         (det_w)
   );

   dp_fault_regs #(
      .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .det      (det_w),
      .mask_q   (mask_q),
      .stat_q   (stat_q)
   );

   assign err_irq = |stat_q;
   assign halt    = |stat_q;
endmodule

// File: rtl/dp_fault_watch_chk.sv
module dp_fault_watch_chk
   import dp_fault_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              reg_wr,
   input logic              reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              err_irq,
   input logic              halt,
   input err_vec_t          det,
   input err_vec_t          mask,
   input err_vec_t          stat
);
   err_vec_t clr_chk;
   assign clr_chk = (reg_wr && reg_addr) ? reg_wdata[NUM_ERR-1:0] : '0;

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (stat == '0 && mask == '0));

   // R8
   p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(det & ~mask)) && !soft_rst) |=> (err_irq && halt));

   // R7
   p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((det & ~mask) == '0) && clr_chk == '0 && !soft_rst) |=> $stable(stat));

   // R9
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> ((($past(stat) & ~$past(clr_chk)) & ~stat) == '0));

   // R10
   p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !soft_rst && clr_chk == '0) |=> halt);

   // R10
   p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!halt && !err_irq));

   // R11
   p_all_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> (($past(det) & ~$past(mask) & ~stat) == '0));
endmodule

bind dp_fault_watch dp_fault_watch_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .err_irq  (err_irq),
   .halt     (halt),
   .det      (det_w),
   .mask     (mask_q),
   .stat     (stat_q)
);

// File: tb/sim_dp_fault_watch.sv
module sim_dp_fault_watch;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_rst = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_addr = 1'b1;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              in_push = 1'b0;
   logic              in_pop = 1'b0;
   logic              out_pop = 1'b0;
   logic              out_empty = 1'b1;
   logic              size_wr = 1'b0;
   logic              done = 1'b0;
   logic              icv_mismatch = 1'b0;
   logic              err_irq;
   logic              halt;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic              addr;
      logic [DATA_W-1:0] data;
      logic              flag;
      string             tag;
   } exp_t;

   exp_t sb_q[$];

   always #2 clk = ~clk;

   dp_fault_watch #(.DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .in_push(in_push), .in_pop(in_pop), .out_pop(out_pop), .out_empty(out_empty),
      .size_wr(size_wr), .done(done), .icv_mismatch(icv_mismatch),
      .err_irq(err_irq), .halt(halt)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // monitor: pops expectations and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (reg_rdata !== e.data) begin
               n_fail++;
               $display("FAIL %s: rdata addr %0d actual %h expected %h", e.tag, e.addr, reg_rdata, e.data);
            end
            n_chk++;
            if (err_irq !== e.flag || halt !== e.flag) begin
               n_fail++;
               $display("FAIL %s: irq/halt actual %b/%b expected %b", e.tag, err_irq, halt, e.flag);
            end
         end
      end
   end

   initial begin
      #400000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   task automatic expect_reg(input logic a, input logic [DATA_W-1:0] d, input logic f, input string tag);
      exp_t e;
      reg_addr = a;
      e.addr = a; e.data = d; e.flag = f; e.tag = tag;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
      @(posedge clk); #1;
   endtask

   task automatic reg_write(input logic a, input logic [DATA_W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      // R1
      expect_reg(1'b1, 8'h00, 1'b0, "R1 status");
      expect_reg(1'b0, 8'h00, 1'b0, "R1 mask");

      // R6 R8
      icv_mismatch = 1'b1; @(posedge clk); #1; icv_mismatch = 1'b0;
      expect_reg(1'b1, 8'h01, 1'b1, "R6 R8 integrity");
      idle(3);
      expect_reg(1'b1, 8'h01, 1'b1, "R10 halt holds");
      reg_write(1'b1, 8'h00);
      expect_reg(1'b1, 8'h01, 1'b1, "R9 write zero");
      reg_write(1'b1, 8'h01);
      expect_reg(1'b1, 8'h00, 1'b0, "R9 R10 w1c");

      // R2
      out_empty = 1'b0; out_pop = 1'b1; @(posedge clk); #1; out_pop = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R2 pop nonempty");
      out_empty = 1'b1; out_pop = 1'b1; @(posedge clk); #1; out_pop = 1'b0;
      expect_reg(1'b1, 8'h04, 1'b1, "R2 underflow");
      reg_write(1'b1, 8'h04);

      // R3
      in_push = 1'b1; idle(32); in_push = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R3 fill to limit");
      in_push = 1'b1; @(posedge clk); #1; in_push = 1'b0;
      expect_reg(1'b1, 8'h02, 1'b1, "R3 overflow");
      reg_write(1'b1, 8'h02);

      // R4
      done = 1'b1; @(posedge clk); #1; done = 1'b0;
      expect_reg(1'b1, 8'h08, 1'b1, "R4 input leftover");
      in_pop = 1'b1; idle(32); in_pop = 1'b0;
      reg_write(1'b1, 8'h08);
      done = 1'b1; @(posedge clk); #1; done = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R4 done empty");

      // R5
      out_empty = 1'b0; size_wr = 1'b1; @(posedge clk); #1; size_wr = 1'b0;
      expect_reg(1'b1, 8'h10, 1'b1, "R5 output leftover");
      reg_write(1'b1, 8'h10);
      out_empty = 1'b1; size_wr = 1'b1; @(posedge clk); #1; size_wr = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R5 size write empty");

      // R7 R12
      reg_write(1'b0, 8'h1F);
      expect_reg(1'b0, 8'h1F, 1'b0, "R12 mask readback");
      icv_mismatch = 1'b1; out_pop = 1'b1; @(posedge clk); #1;
      icv_mismatch = 1'b0; out_pop = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R7 all masked");

      // R11 R7
      reg_write(1'b0, 8'h01);
      out_empty = 1'b1;
      icv_mismatch = 1'b1; out_pop = 1'b1; @(posedge clk); #1;
      icv_mismatch = 1'b0; out_pop = 1'b0;
      out_empty = 1'b0; size_wr = 1'b1; @(posedge clk); #1; size_wr = 1'b0;
      expect_reg(1'b1, 8'h14, 1'b1, "R11 R7 mixed");
      icv_mismatch = 1'b1; out_empty = 1'b1; out_pop = 1'b1; done = 1'b1;
      in_push = 1'b0; @(posedge clk); #1;
      icv_mismatch = 1'b0; out_pop = 1'b0; done = 1'b0;
      reg_write(1'b0, 8'h00);
      reg_write(1'b1, 8'h14);
      out_empty = 1'b0; size_wr = 1'b1; icv_mismatch = 1'b1; @(posedge clk); #1;
      size_wr = 1'b0; icv_mismatch = 1'b0;
      expect_reg(1'b1, 8'h11, 1'b1, "R11 same cycle");

      // R9 partial clear
      reg_write(1'b1, 8'h01);
      expect_reg(1'b1, 8'h10, 1'b1, "R9 partial clear");

      // R10 soft reset keeps mask
      reg_write(1'b0, 8'h02);
      soft_rst = 1'b1; @(posedge clk); #1; soft_rst = 1'b0;
      expect_reg(1'b1, 8'h00, 1'b0, "R10 soft reset");
      expect_reg(1'b0, 8'h02, 1'b0, "R10 mask kept");

      idle(2);
      finish_run();
   end
endmodule